// File: doc/BRIEF.md
# SDRAM Bring-up and Refresh Sequencer

This block owns the command pins of a two-bank synchronous DRAM from reset onward. It first holds the device idle with clock enable and the data mask raised and presents NOP for a stabilisation window. It then closes every bank, runs a programmable number of auto-refresh cycles, and loads the mode register from a word supplied at its input. After a short lockout it raises `init_done`, and from then on it keeps a refresh timer running. When a refresh falls due, the block asks a user arbiter for the bus and issues an auto-refresh once the arbiter grants it.

All timing is given in nanoseconds or microseconds together with the clock frequency in MHz. The block converts each figure to whole clocks, rounding up. The refresh handshake follows valid/ready rules. `ref_req` acts as valid. `ref_gnt` acts as ready and provides the back-pressure. A request stays raised until a clock edge sees both signals high. A grant seen while no request is raised has no effect. Refresh periods that fall due while the arbiter is holding back are counted and are not dropped. The count saturates at `OWE_MAX`. The owed refreshes are then issued one after another, each spaced by the row cycle time.

In this brief, cycle n is the interval after the n-th rising clock edge that follows the release of `rst_n`. The term "pins" means the registered command outputs.

Top module: `sdram_bringup_seq`

## Requirements
- R1: During reset, and in every cycle until `init_done` rises, `sd_cke` and `sd_dqm` are 1. Before the first precharge, every cycle presents NOP, which is `sd_cs_n`=0 and `sd_ras_n`=`sd_cas_n`=`sd_we_n`=1. `init_done` and `ref_req` are 0 during reset.
- R2: The first command other than NOP is a precharge. It appears in cycle `WAIT_US*CLK_MHZ+1`.
- R3: The precharge is encoded as `sd_ras_n`=0, `sd_cas_n`=1 and `sd_we_n`=0, with `sd_addr[10]`=1 so that it closes all banks.
- R4: After the precharge, exactly `NUM_AREF` auto-refreshes follow. An auto-refresh is encoded as `sd_ras_n`=0, `sd_cas_n`=0 and `sd_we_n`=1. The first comes `ceil(TRP_NS*CLK_MHZ/1000)` cycles after the precharge. Each following one comes `TRC = ceil(TRC_NS*CLK_MHZ/1000)` cycles after the one before it.
- R5: A mode register set, with all three strobes at 0, appears TRC cycles after the last start-up refresh. On it, `sd_addr` equals `mode_word` with bits 10, 8 and 7 forced to 0, and `sd_ba` is 0.
- R6: `init_done` first rises exactly `MRD_CLKS` cycles after the mode register set. Only NOP appears in between, and `init_done` then stays 1.
- R7: `ref_req` is 0 in every cycle before `init_done` is 1.
- R8: Let D be the first cycle in which `init_done` is 1. A refresh falls due at cycle D+k*REFI for every k ≥ 1, where `REFI = ceil(REFI_NS*CLK_MHZ/1000)`. When no refresh is owed and none is in progress, `ref_req` rises in that cycle.
- R9: `ref_req` falls only after an edge at which `ref_gnt` was 1. An edge that sees `ref_req` and `ref_gnt` both at 1 makes the next cycle an auto-refresh with `ref_req` at 0. A grant without a request has no effect. After `init_done`, no other command is issued.
- R10: After a run-time auto-refresh, `ref_req` stays 0 for TRC cycles. When further refreshes are owed, it rises again exactly TRC cycles later.
- R11: The refresh timer keeps counting while a request waits for its grant. Periods missed during a stall are all issued later, so the total number of auto-refreshes matches the number of elapsed periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every output is registered on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_word | input | ROW_W | Mode value, sampled in the cycle the mode register set is issued |
| ref_gnt | input | 1 | Arbiter grant (ready) for a pending refresh |
| ref_req | output | 1 | Refresh pending (valid) |
| init_done | output | 1 | Bring-up finished; the device is ready for traffic |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_dqm | output | 1 | Data mask |
| sd_ba | output | BA_W | Bank select |
| sd_addr | output | ROW_W | Multiplexed address; bit 10 selects all banks on precharge |

## Verification
The hardest state to reach from the ports is a backlog of several owed refreshes. Getting there requires the arbiter to hold off for more than one full refresh period, which is far longer than any ordinary grant delay. The stimulus uses random grant delays and stray grants for a dozen periods. It then withholds every grant across four period boundaries and afterwards grants at once. This forces back-to-back refreshes spaced by the row cycle time. At a point halfway between two due times, the total refresh count is compared with the number of elapsed periods.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

  typedef enum logic [1:0] {
    CMD_NOP,
    CMD_PALL,
    CMD_AREF,
    CMD_MRS
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    ST_POWUP,
    ST_PRECH,
    ST_INIT_RC,
    ST_MRD,
    ST_RUN,
    ST_RUN_RC
  } sdr_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sdr_pins_t;

  // whole clocks covering a span in ns, rounded up
  function automatic int ns_to_clks(input int ns, input int mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

  function automatic sdr_pins_t encode(input sdr_cmd_e c);
    sdr_pins_t p;
    p.cs_n = 1'b0;
    case (c)
      CMD_PALL: {p.ras_n, p.cas_n, p.we_n} = 3'b010;
      CMD_AREF: {p.ras_n, p.cas_n, p.we_n} = 3'b001;
      CMD_MRS:  {p.ras_n, p.cas_n, p.we_n} = 3'b000;
      default:  {p.ras_n, p.cas_n, p.we_n} = 3'b111;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sdr_refi_timer.sv
module sdr_refi_timer #(
  parameter int REFI_CK = 1560,
  parameter int OWE_MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic take,
  output logic due_next
);
  localparam int TW = $clog2(REFI_CK + 1);
  localparam int OW = $clog2(OWE_MAX + 1);

  logic [TW-1:0] tmr_q;
  logic [OW-1:0] owed_q, owed_d;
  logic          tick;

  assign tick = run && (tmr_q == TW'(REFI_CK - 1));

  always_comb begin
    owed_d = owed_q;
    if (tick && !take) begin
      if (owed_q != OW'(OWE_MAX)) owed_d = owed_q + 1'b1;
    end else if (!tick && take) begin
      owed_d = owed_q - 1'b1;
    end
  end

  assign due_next = (owed_d != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      owed_q <= '0;
    end else begin
      owed_q <= owed_d;
      if (!run || tick) tmr_q <= '0;
      else              tmr_q <= tmr_q + 1'b1;
    end
  end
endmodule

// File: rtl/sdr_seq_fsm.sv
module sdr_seq_fsm
  import sdr_seq_pkg::*;
#(
  parameter int N_WAIT   = 20000,
  parameter int TRP_CK   = 2,
  parameter int TRC_CK   = 7,
  parameter int MRD_CK   = 2,
  parameter int NUM_AREF = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ref_gnt,
  input  logic     due_next,
  output sdr_cmd_e cmd,
  output logic     take,
  output logic     done_q,
  output logic     req_q
);
  localparam int CW = $clog2(N_WAIT + TRP_CK + TRC_CK + MRD_CK + 1);
  localparam int AW = $clog2(NUM_AREF + 1);

  sdr_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] aref_q, aref_d;
  logic          done_d, req_d, zero;

  assign zero = (cnt_q == '0);
  assign take = (state_q == ST_RUN) && req_q && ref_gnt;

  always_comb begin
    state_d = state_q;
    cnt_d   = zero ? cnt_q : cnt_q - 1'b1;
    aref_d  = aref_q;
    done_d  = done_q;
    cmd     = CMD_NOP;
    case (state_q)
      ST_POWUP: if (zero) begin
        cmd     = CMD_PALL;
        state_d = ST_PRECH;
        cnt_d   = CW'(TRP_CK - 1);
      end
      ST_PRECH: if (zero) begin
        cmd     = CMD_AREF;
        aref_d  = AW'(1);
        state_d = ST_INIT_RC;
        cnt_d   = CW'(TRC_CK - 1);
      end
      ST_INIT_RC: if (zero) begin
        if (aref_q == AW'(NUM_AREF)) begin
          cmd     = CMD_MRS;
          state_d = ST_MRD;
          cnt_d   = CW'(MRD_CK - 1);
        end else begin
          cmd     = CMD_AREF;
          aref_d  = aref_q + 1'b1;
          cnt_d   = CW'(TRC_CK - 1);
        end
      end
      ST_MRD: if (zero) begin
        state_d = ST_RUN;
        done_d  = 1'b1;
      end
      ST_RUN: if (take) begin
        cmd     = CMD_AREF;
        state_d = ST_RUN_RC;
        cnt_d   = CW'(TRC_CK - 1);
      end
      ST_RUN_RC: if (zero) state_d = ST_RUN;
      default: state_d = ST_POWUP;
    endcase
    req_d = (state_d == ST_RUN) && due_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_POWUP;
      cnt_q   <= CW'(N_WAIT);
      aref_q  <= '0;
      done_q  <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      aref_q  <= aref_d;
      done_q  <= done_d;
      req_q   <= req_d;
    end
  end
endmodule

// File: rtl/sdr_pin_drive.sv
module sdr_pin_drive
  import sdr_seq_pkg::*;
#(
  parameter int ROW_W  = 11,
  parameter int BA_W   = 1,
  parameter int AP_BIT = 10,
  parameter int TM_LO  = 7,
  parameter int WB_BIT = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sdr_cmd_e         cmd,
  input  logic [ROW_W-1:0] mode_word,
  output logic             sd_cke,
  output logic             sd_dqm,
  output sdr_pins_t        pins,
  output logic [BA_W-1:0]  sd_ba,
  output logic [ROW_W-1:0] sd_addr
);
  // burst/latency/type bits and the write-burst bit pass; reserved and test bits go to 0
  function automatic logic [ROW_W-1:0] keep_mask();
    logic [ROW_W-1:0] m;
    for (int i = 0; i < ROW_W; i++) m[i] = (i < TM_LO) || (i == WB_BIT);
    return m;
  endfunction
  localparam logic [ROW_W-1:0] MODE_MASK = keep_mask();

  logic [ROW_W-1:0] addr_d;
  sdr_pins_t        pins_d;

  always_comb begin
    pins_d = encode(cmd);
    addr_d = '0;
    case (cmd)
      CMD_PALL: addr_d[AP_BIT] = 1'b1;
      CMD_MRS:  addr_d = mode_word & MODE_MASK;
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sd_cke  <= 1'b1;
      sd_dqm  <= 1'b1;
      pins    <= encode(CMD_NOP);
      sd_ba   <= '0;
      sd_addr <= '0;
    end else begin
      sd_cke  <= 1'b1;
      sd_dqm  <= 1'b1;
      pins    <= pins_d;
      sd_ba   <= '0;
      sd_addr <= addr_d;
    end
  end
endmodule

// File: rtl/sdram_bringup_seq.sv
module sdram_bringup_seq
  import sdr_seq_pkg::*;
#(
  parameter int CLK_MHZ  = 100,
  parameter int WAIT_US  = 200,
  parameter int TRP_NS   = 20,
  parameter int TRC_NS   = 70,
  parameter int REFI_NS  = 15600,
  parameter int NUM_AREF = 2,
  parameter int MRD_CLKS = 2,
  parameter int OWE_MAX  = 8,
  parameter int ROW_W    = 11,
  parameter int BA_W     = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROW_W-1:0] mode_word,
  input  logic             ref_gnt,
  output logic             ref_req,
  output logic             init_done,
  output logic             sd_cke,
  output logic             sd_cs_n,
  output logic             sd_ras_n,
  output logic             sd_cas_n,
  output logic             sd_we_n,
  output logic             sd_dqm,
  output logic [BA_W-1:0]  sd_ba,
  output logic [ROW_W-1:0] sd_addr
);
  localparam int N_WAIT  = WAIT_US * CLK_MHZ;
  localparam int TRP_CK  = ns_to_clks(TRP_NS, CLK_MHZ);
  localparam int TRC_CK  = ns_to_clks(TRC_NS, CLK_MHZ);
  localparam int REFI_CK = ns_to_clks(REFI_NS, CLK_MHZ);

  sdr_cmd_e  cmd;
  sdr_pins_t pins;
  logic      take, due_next;

  sdr_seq_fsm #(
    .N_WAIT(N_WAIT), .TRP_CK(TRP_CK), .TRC_CK(TRC_CK),
    .MRD_CK(MRD_CLKS), .NUM_AREF(NUM_AREF)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .due_next(due_next),
    .cmd(cmd), .take(take), .done_q(init_done), .req_q(ref_req)
  );

  sdr_refi_timer #(.REFI_CK(REFI_CK), .OWE_MAX(OWE_MAX)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(init_done), .take(take), .due_next(due_next)
  );

  sdr_pin_drive #(.ROW_W(ROW_W), .BA_W(BA_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .mode_word(mode_word),
    .sd_cke(sd_cke), .sd_dqm(sd_dqm), .pins(pins), .sd_ba(sd_ba), .sd_addr(sd_addr)
  );

  assign sd_cs_n  = pins.cs_n;
  assign sd_ras_n = pins.ras_n;
  assign sd_cas_n = pins.cas_n;
  assign sd_we_n  = pins.we_n;
endmodule

// File: rtl/sdr_seq_checker.sv
module sdr_seq_checker #(
  parameter int ROW_W = 11,
  parameter int BA_W  = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [ROW_W-1:0] mode_word,
  input logic             ref_gnt,
  input logic             ref_req,
  input logic             init_done,
  input logic             sd_cke,
  input logic             sd_cs_n,
  input logic             sd_ras_n,
  input logic             sd_cas_n,
  input logic             sd_we_n,
  input logic             sd_dqm,
  input logic [BA_W-1:0]  sd_ba,
  input logic [ROW_W-1:0] sd_addr
);
  logic is_pall, is_aref, is_mrs;
  assign is_pall = !sd_cs_n && !sd_ras_n &&  sd_cas_n && !sd_we_n;
  assign is_aref = !sd_cs_n && !sd_ras_n && !sd_cas_n &&  sd_we_n;
  assign is_mrs  = !sd_cs_n && !sd_ras_n && !sd_cas_n && !sd_we_n;

  AST_INIT_PINS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> (sd_cke && sd_dqm)) else $error("init pins"); // R1
  AST_PALL_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
    is_pall |-> sd_addr[10]) else $error("pall ap"); // R3
  AST_MRS_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> (sd_ba == '0 && !sd_addr[10] && sd_addr[8:7] == 2'b00)) else $error("mrs rsvd"); // R5
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done) else $error("done drop"); // R6
  AST_NO_REQ_IN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !ref_req) else $error("early req"); // R7
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_gnt) |=> ref_req) else $error("req dropped"); // R9
  AST_GRANT_GIVES_AREF: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_gnt) |=> (is_aref && !ref_req)) else $error("no aref"); // R9
  AST_NO_MRS_AFTER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> !(is_mrs || is_pall)) else $error("late init cmd"); // R9
endmodule

bind sdram_bringup_seq sdr_seq_checker #(.ROW_W(ROW_W), .BA_W(BA_W)) u_chk (.*);

// File: tb/sdram_bringup_seq_bench.sv
module sdram_bringup_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MHZ    = 100;
  localparam int B_WAIT = 200 * MHZ;
  localparam int B_TRP  = (20 * MHZ + 999) / 1000;
  localparam int B_TRC  = (70 * MHZ + 999) / 1000;
  localparam int B_REFI = (15600 * MHZ + 999) / 1000;
  localparam int B_MRD  = 2;
  localparam int B_NAREF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [10:0] mode_word = '0;
  logic ref_gnt = 1'b0;
  logic ref_req, init_done, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm;
  logic [0:0] sd_ba;
  logic [10:0] sd_addr;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sdram_bringup_seq u_sdram_bringup_seq (
    .clk(clk), .rst_n(rst_n), .mode_word(mode_word), .ref_gnt(ref_gnt),
    .ref_req(ref_req), .init_done(init_done), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_dqm(sd_dqm),
    .sd_ba(sd_ba), .sd_addr(sd_addr)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // 0 NOP, 1 precharge, 2 auto-refresh, 3 mode set, 4 other
  function automatic int dec();
    if (sd_cs_n) return 4;
    case ({sd_ras_n, sd_cas_n, sd_we_n})
      3'b111: return 0;
      3'b010: return 1;
      3'b001: return 2;
      3'b000: return 3;
      default: return 4;
    endcase
  endfunction

  function automatic logic [10:0] exp_mode(input logic [10:0] w);
    return w & 11'h27F;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int cyc = 0;
    int ncmd = 0;
    int ccyc[8];
    int ckind[8];
    logic [10:0] caddr[8];
    logic [0:0] cba[8];
    int bad1 = 0, bad7 = 0, bad6 = 0, bad9 = 0;
    int d_cyc, last_aref, nref, nbb, dly, rel;
    bit prev_req, prev_gnt, first_rise;
    void'($urandom(32'h5EED_0C1B));
    mode_word = 11'($urandom) | 11'h580;  // reserved bits set on purpose

    repeat (3) @(negedge clk);
    check(sd_cke && sd_dqm && dec() == 0 && !init_done && !ref_req, "R1 reset state",
          {sd_cke, sd_dqm, init_done, ref_req}, 4'b1100);
    rst_n = 1'b1;

    // bring-up phase
    while (!init_done && cyc < B_WAIT + 400) begin
      @(posedge clk); @(negedge clk); cyc++;
      if (!(sd_cke && sd_dqm)) bad1++;
      if (ref_req) bad7++;
      if (dec() != 0 && ncmd < 8) begin
        ccyc[ncmd] = cyc; ckind[ncmd] = dec(); caddr[ncmd] = sd_addr; cba[ncmd] = sd_ba;
        ncmd++;
      end
    end
    d_cyc = cyc;
    check(bad1 == 0, "R1 cke/dqm high during init", bad1, 0);
    check(bad7 == 0, "R7 no request before init_done", bad7, 0);
    check(init_done, "R6 init_done reached", init_done, 1);
    check(ncmd == B_NAREF + 2, "R6 command count during init", ncmd, B_NAREF + 2);
    if (ncmd == B_NAREF + 2) begin
      check(ckind[0] == 1, "R2 first command is precharge", ckind[0], 1);
      check(ccyc[0] == B_WAIT + 1, "R2 precharge cycle", ccyc[0], B_WAIT + 1);
      check(caddr[0][10] == 1'b1, "R3 precharge all banks", caddr[0][10], 1);
      for (int i = 1; i <= B_NAREF; i++) begin
        check(ckind[i] == 2, "R4 startup auto-refresh", ckind[i], 2);
        check(ccyc[i] - ccyc[i-1] == ((i == 1) ? B_TRP : B_TRC), "R4 startup spacing",
              ccyc[i] - ccyc[i-1], (i == 1) ? B_TRP : B_TRC);
      end
      check(ckind[B_NAREF+1] == 3, "R5 mode set command", ckind[B_NAREF+1], 3);
      check(ccyc[B_NAREF+1] - ccyc[B_NAREF] == B_TRC, "R5 mode set spacing",
            ccyc[B_NAREF+1] - ccyc[B_NAREF], B_TRC);
      check(caddr[B_NAREF+1] == exp_mode(mode_word), "R5 mode word masked",
            caddr[B_NAREF+1], exp_mode(mode_word));
      check(cba[B_NAREF+1] == '0, "R5 bank bits zero", cba[B_NAREF+1], 0);
      check(d_cyc - ccyc[B_NAREF+1] == B_MRD, "R6 lockout after mode set",
            d_cyc - ccyc[B_NAREF+1], B_MRD);
    end

    // run phase: random grants, then a stall, then immediate grants
    last_aref = -1000000; nref = 0; nbb = 0; dly = 0;
    prev_req = ref_req; prev_gnt = 0; first_rise = 1;
    rel = 0;
    while (rel != 20 * B_REFI + B_REFI / 2) begin
      int k;
      bit stall, catchup;
      @(posedge clk); @(negedge clk); cyc++;
      rel = cyc - d_cyc;
      stall   = (rel >= 12 * B_REFI + B_REFI / 2) && (rel < 16 * B_REFI + B_REFI / 2);
      catchup = (rel >= 16 * B_REFI + B_REFI / 2);
      k = dec();
      if (!init_done) bad6++;
      if (prev_req && !ref_req && !prev_gnt) bad9++;
      if (prev_req && prev_gnt) begin
        check(k == 2 && !ref_req, "R9 grant yields auto-refresh", k, 2);
        if (k == 2) begin nref++; last_aref = cyc; end
      end else if (k != 0) begin
        check(0, "R9 unexpected command", k, 0);
      end
      if (ref_req && !prev_req) begin
        if (first_rise) begin
          check(rel == B_REFI, "R8 first refresh due", rel, B_REFI);
          first_rise = 0;
        end
        check(cyc - last_aref >= B_TRC, "R10 row cycle gap", cyc - last_aref, B_TRC);
        if (cyc - last_aref != B_TRC)
          check(rel % B_REFI == 0, "R8 request on period boundary", rel % B_REFI, 0);
        else if (catchup) nbb++;
      end
      if (ref_req) begin
        if (stall) ref_gnt = 1'b0;
        else if (dly == 0) ref_gnt = 1'b1;
        else begin dly--; ref_gnt = 1'b0; end
      end else begin
        ref_gnt = !stall && !catchup && ($urandom % 8 == 0);
        dly = catchup ? 0 : int'($urandom % 41);
      end
      prev_req = ref_req; prev_gnt = ref_gnt;
    end
    check(bad6 == 0, "R6 init_done stays high", bad6, 0);
    check(bad9 == 0, "R9 request held until grant", bad9, 0);
    check(nref == 20, "R11 refresh count after stall", nref, 20);
    check(nbb == 3, "R10 R11 back-to-back owed refreshes", nbb, 3);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule